// File: doc/BRIEF.md
# Dual Programmable Coarse Delay Line

This block delays two independent sample streams by a whole number of samples. Each stream writes into its own circular buffer. The output is read back from the location that lies a programmed number of writes behind the write pointer. A single 32-bit control word carries, for each channel, an enable bit and a 15-bit delay request.

A channel whose enable is cleared skips the buffer and leaves through a one-register bypass. An enabled channel passes through a read stage and the output register, so it arrives one clock later than a bypassed one. Both enabled channels have the same latency, so two enabled channels with equal settings stay aligned. Enabling only one channel leaves a one-cycle skew between them, even when both delays are zero.

When a delay changes, older buffer contents no longer mean anything. A per-channel settled flag rises once enough samples have been written since the change to cover the new depth. The buffer depth is a parameter, `BUF_AW` address bits. Set it to 15 for the full 0 to 32767 range.

Top module: `cdl_dual`

## Requirements
- R1: After reset, every `out_valid` and `out_settled` bit is 0.
- R2: Control word fields: bit 30 enables channel 0 and bits 14:0 are its delay; bit 31 enables channel 1 and bits 29:15 are its delay.
- R3: On an enabled channel with delay d, a sample accepted at clock edge k appears at edge k+2 with `out_valid`=1. When `out_settled`=1, `out_data` equals the sample accepted d accepted-samples earlier on that channel. `out_settled` is never 1 while `out_valid` is 0.
- R4: On a disabled channel, the outputs at edge k+1 repeat the inputs at edge k: `out_valid`=`in_valid`, `out_data`=`in_data`, and `out_settled`=`in_valid`.
- R5: With delay 0, an enabled channel outputs the current sample itself, settled, two edges after acceptance. This is one edge later than a disabled channel.
- R6: `out_settled` stays 0 until at least d samples have been written since the last restart. A restart happens on the first enabled cycle, or on an enabled cycle whose delay differs from the previous cycle's.
- R7: A delay request above 2^BUF_AW-1 is treated as 2^BUF_AW-1.
- R8: A channel accepts at most one sample per clock. Cycles with `in_valid`=0 neither write nor advance the buffer, and they produce `out_valid`=0 at the matching output edge.
- R9: The two channels are independent. Each follows only its own enable, delay, valid and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Enables and delay requests for both channels |
| in_valid | input | 2 | Sample strobe per channel |
| in_data | input | 2 x SW | Input sample per channel |
| out_valid | output | 2 | Output strobe per channel |
| out_data | output | 2 x SW | Delayed sample per channel |
| out_settled | output | 2 | Output data reflects the requested delay |

## Verification
A wrong write or read pointer shows up as wrong data the first time a settled sample is read, which is d accepted samples after the fault. The bench's reference history catches it on that same cycle. A wrong fill count shows up as `out_settled` rising earlier or later than the d-th write after a restart. A latency mismatch between the bypass and enabled paths shows up at once as misplaced `out_valid` strobes, because the output is compared on every clock.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  localparam int CTRL_W = 32;
  localparam int DLY_W  = 15;
  localparam int NCH    = 2;

  // enable bit of channel ch: channel 0 at bit 30, channel 1 at bit 31
  function automatic logic ctrl_en(input logic [CTRL_W-1:0] w, input int ch);
    return w[30 + ch];
  endfunction

  // delay field of channel ch: 15 bits starting at bit 15*ch
  function automatic logic [DLY_W-1:0] ctrl_dly(input logic [CTRL_W-1:0] w, input int ch);
    return w[DLY_W*ch +: DLY_W];
  endfunction

  // limit a request to the deepest usable delay
  function automatic logic [DLY_W-1:0] clamp_dly(input logic [DLY_W-1:0] req,
                                                input logic [DLY_W-1:0] maxv);
    return (req > maxv) ? maxv : req;
  endfunction
endpackage

// File: rtl/cdl_ring.sv
module cdl_ring #(
  parameter int SW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] dly,
  input  logic          in_valid,
  input  logic [SW-1:0] in_data,
  output logic          a_valid,
  output logic [SW-1:0] a_data,
  output logic          a_full
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] FILL_MAX = AW'(DEPTH - 1);

  logic [SW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr, fill, fill_eff, d_prev;
  logic          en_prev;
  logic          restart, wr_ev;

  // internal events brought out for the assertions
  assign restart  = en && (!en_prev || (dly != d_prev));
  assign wr_ev    = en && in_valid;
  assign fill_eff = restart ? '0 : fill;
  assign rptr     = wptr - dly;

  always_ff @(posedge clk) begin
    if (wr_ev) mem[wptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      fill    <= '0;
      d_prev  <= '0;
      en_prev <= 1'b0;
      a_valid <= 1'b0;
      a_full  <= 1'b0;
      a_data  <= '0;
    end else begin
      d_prev  <= dly;
      en_prev <= en;
      a_valid <= wr_ev;
      a_full  <= wr_ev && (fill_eff >= dly);
      if (wr_ev) begin
        wptr   <= wptr + 1'b1;
        a_data <= (dly == '0) ? in_data : mem[rptr];
        fill   <= (fill_eff == FILL_MAX) ? FILL_MAX : fill_eff + 1'b1;
      end else if (en) begin
        fill <= fill_eff;
      end
    end
  end

  p_wptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> (wptr == AW'($past(wptr) + 1'b1)));
  p_wptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> $stable(wptr));
  p_restart_unsettled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && in_valid && dly != '0) |=> !a_full);
  p_zero_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && dly == '0) |=> (a_full && a_data == $past(in_data)));
endmodule

// File: rtl/cdl_lane.sv
module cdl_lane
  import cdl_pkg::*;
#(
  parameter int SW = 16,
  parameter int AW = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DLY_W-1:0] dly_req,
  input  logic             in_valid,
  input  logic [SW-1:0]    in_data,
  output logic             out_valid,
  output logic [SW-1:0]    out_data,
  output logic             out_settled
);
  localparam logic [DLY_W-1:0] DLY_MAX = DLY_W'((1 << AW) - 1);

  logic [DLY_W-1:0] dly_lim;
  logic [AW-1:0]    dly;
  logic             a_valid, a_full;
  logic [SW-1:0]    a_data;

  assign dly_lim = clamp_dly(dly_req, DLY_MAX);
  assign dly     = dly_lim[AW-1:0];

  cdl_ring #(.SW(SW), .AW(AW)) ring_i (
    .clk(clk), .rst_n(rst_n), .en(en), .dly(dly),
    .in_valid(in_valid), .in_data(in_data),
    .a_valid(a_valid), .a_data(a_data), .a_full(a_full)
  );

  // output register: enabled path adds the read stage, bypass does not
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_settled <= 1'b0;
      out_data    <= '0;
    end else if (en) begin
      out_valid   <= a_valid;
      out_settled <= a_full;
      out_data    <= a_data;
    end else begin
      out_valid   <= in_valid;
      out_settled <= in_valid;
      out_data    <= in_data;
    end
  end

  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (out_valid == $past(in_valid) && out_data == $past(in_data)
             && out_settled == $past(in_valid)));
  p_settled_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_settled |-> out_valid);
  p_enabled_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(rst_n)) |=> (out_valid == $past(in_valid, 2)));
endmodule

// File: rtl/cdl_dual.sv
module cdl_dual
  import cdl_pkg::*;
#(
  parameter int SW     = 16,
  parameter int BUF_AW = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CTRL_W-1:0]        ctrl_word,
  input  logic [NCH-1:0]           in_valid,
  input  logic [NCH-1:0][SW-1:0]   in_data,
  output logic [NCH-1:0]           out_valid,
  output logic [NCH-1:0][SW-1:0]   out_data,
  output logic [NCH-1:0]           out_settled
);
  initial begin
    if (BUF_AW < 1 || BUF_AW > DLY_W) $error("BUF_AW out of range");
  end

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic             ch_en;
    logic [DLY_W-1:0] ch_dly;
    assign ch_en  = ctrl_en(ctrl_word, c);
    assign ch_dly = ctrl_dly(ctrl_word, c);

    cdl_lane #(.SW(SW), .AW(BUF_AW)) lane_i (
      .clk(clk), .rst_n(rst_n), .en(ch_en), .dly_req(ch_dly),
      .in_valid(in_valid[c]), .in_data(in_data[c]),
      .out_valid(out_valid[c]), .out_data(out_data[c]),
      .out_settled(out_settled[c])
    );
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (out_valid == '0 && out_settled == '0));
endmodule

// File: tb/cdl_dual_tb.sv
module cdl_dual_tb_top;
  localparam int SW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [1:0] in_valid = '0;
  logic [1:0][SW-1:0] in_data = '0;
  logic [1:0] out_valid, out_settled;
  logic [1:0][SW-1:0] out_data;

  always #10 clk = ~clk;

  cdl_dual #(.SW(SW), .BUF_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_settled(out_settled)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [SW-1:0] hist [2][$];
  int  fill [2];
  bit  pen [2];
  int  pd [2];
  bit  av [2], af [2], ov [2], os [2];
  logic [SW-1:0] ad [2], od [2];
  logic [SW-1:0] lfsr [2];

  function automatic logic [31:0] mk(bit e1, bit e0, int d1, int d0);
    logic [31:0] w;
    w = '0;
    w[31] = e1; w[30] = e0;             // R2 enable bits
    w[29:15] = 15'(d1); w[14:0] = 15'(d0); // R2 delay fields
    return w;
  endfunction

  function automatic logic [SW-1:0] nxt(logic [SW-1:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  task automatic model_edge();
    for (int c = 0; c < 2; c++) begin
      bit e, v; int d, eff; logic [SW-1:0] x;
      e = ctrl_word[30 + c];
      d = int'(ctrl_word[15*c +: 15]);
      if (d > DEPTH - 1) d = DEPTH - 1;   // R7 limit
      v = in_valid[c]; x = in_data[c];
      // output stage
      if (e) begin ov[c] = av[c]; os[c] = af[c]; od[c] = ad[c]; end
      else   begin ov[c] = v; os[c] = v; od[c] = x; end
      // delay stage
      eff = (e && (!pen[c] || d != pd[c])) ? 0 : fill[c];
      if (e && v) begin
        av[c] = 1; af[c] = (eff >= d);
        if (d == 0) ad[c] = x;
        else if (hist[c].size() >= d) ad[c] = hist[c][hist[c].size() - d];
        hist[c].push_back(x);
        if (hist[c].size() > DEPTH) void'(hist[c].pop_front());
        fill[c] = (eff + 1 > DEPTH - 1) ? DEPTH - 1 : eff + 1;
      end else begin
        av[c] = 0; af[c] = 0;
        if (e) fill[c] = eff;
      end
      pen[c] = e; pd[c] = d;
    end
  endtask

  task automatic compare(string req);
    for (int c = 0; c < 2; c++) begin
      n_vec++;
      if (out_valid[c] !== ov[c] || out_settled[c] !== os[c] ||
          (os[c] && out_data[c] !== od[c])) begin
        n_bad++;
        $display("FAIL %s ch%0d: got v=%0b s=%0b d=%h, expected v=%0b s=%0b d=%h",
                 req, c, out_valid[c], out_settled[c], out_data[c], ov[c], os[c], od[c]);
      end
    end
  endtask

  task automatic run(string req, logic [31:0] w, int cycles, int gap);
    for (int i = 0; i < cycles; i++) begin
      ctrl_word = w;
      for (int c = 0; c < 2; c++) begin
        lfsr[c] = nxt(lfsr[c]);
        in_data[c] = lfsr[c];
        in_valid[c] = (gap == 0) ? 1'b1 : ((i + c) % gap != 0);
      end
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    lfsr[0] = 16'h1234; lfsr[1] = 16'hBEEF;
    for (int c = 0; c < 2; c++) begin
      fill[c] = 0; pen[c] = 0; pd[c] = 0;
      av[c] = 0; af[c] = 0; ov[c] = 0; os[c] = 0; ad[c] = '0; od[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset state");
    run("R2 R3 R9 distinct delays 5/9", mk(1, 1, 9, 5), 60, 0);
    run("R5 zero delay both enabled", mk(1, 1, 0, 0), 20, 0);
    run("R4 R5 ch1 bypass vs ch0 zero delay", mk(0, 1, 0, 0), 20, 0);
    run("R8 gapped valid delay 4", mk(1, 1, 4, 4), 60, 3);
    run("R6 settle at delay 5", mk(1, 1, 3, 5), 30, 0);
    run("R6 delay change to 12", mk(1, 1, 3, 12), 40, 0);
    run("R7 clamp 100 vs 63", mk(1, 1, 63, 100), 150, 0);
    run("R2 ch0 only enabled", mk(0, 1, 20, 7), 30, 0);
    run("R2 ch1 only enabled", mk(1, 0, 7, 20), 30, 4);
    run("R3 equal delays aligned", mk(1, 1, 10, 10), 40, 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule